// File: doc/BRIEF.md
# Bus Error Machine-Check Router

This block lives inside a host bridge that joins a processor bus to a PCI bus. Six error sources report single-cycle event pulses. Each pulse sets a sticky status bit. Each status bit is paired with an enable bit and with a routing rule that names one of two processor bus masters. The block combines every enabled, set status bit into two active-low machine-check lines, one line per master.

Three routing rules exist:

- Errors seen on the processor bus go to whichever master owned the address bus when the event happened.
- PCI parity and PCI system errors always go to master 0.
- PCI abort errors go to the master that started the failed transaction.
  - If that master cannot be identified, a stored default-master bit picks the target.
  - The default-master bit also picks the target when the bridge itself started the transaction.

Software loads the six enable bits and the default-master bit with a single configuration write. It reads the status vector directly. It clears status bits by writing ones to them.

Top module: `mcheck_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, all status bits, all enable bits and the default-master bit clear. Both `mcheck_n` bits read 1 from the following cycle.
- R2: An `err_evt[i]` pulse sampled at a clock edge makes `err_status[i]` read 1 after that edge. The bit positions are: 0 address-bus time-out, 1 processor data parity, 2 PCI parity, 3 PCI system error, 4 signalled master abort, 5 received target abort.
- R3: A set status bit stays set until a clock edge where `status_clr[i]` is 1. At that edge it clears, unless `err_evt[i]` is also 1, in which case it stays set.
- R4: A status bit whose enable bit is 0 is still recorded in `err_status`, but it pulls neither `mcheck_n` line low.
- R5: Sources 0 and 1 are routed to the master index on `abus_master` at the edge where the status bit is captured.
- R6: Sources 2 and 3 are always routed to master 0.
- R7: Sources 4 and 5 are routed to `evt_init_id` when `evt_init_valid` is 1 and `evt_bridge_init` is 0 at the capture edge.
- R8: Otherwise, sources 4 and 5 are routed to the default-master bit as stored at the capture edge (1 means master 1, 0 means master 0).
- R9: `mcheck_n[m]` is 0 exactly one cycle after some status bit is set, enabled and routed to master m. Otherwise it is 1.
- R10: A clock edge with `cfg_we` = 1 loads `cfg_enable` into the enable bits and `cfg_dflt` into the default-master bit. The new values show on `mcheck_n` one cycle later.
- R11: A target is captured only when an event arrives while the bit is clear or is being cleared. A repeat event on a bit that stays set keeps the original target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt | input | 6 | One-cycle error event pulses, one per source |
| evt_init_id | input | 1 | Master index that started the PCI transaction |
| evt_init_valid | input | 1 | `evt_init_id` can be trusted |
| evt_bridge_init | input | 1 | The bridge itself started the transaction |
| abus_master | input | 1 | Current processor address-bus master index |
| cfg_we | input | 1 | Load enables and default-master bit |
| cfg_enable | input | 6 | Enable bits to load |
| cfg_dflt | input | 1 | Default-master bit to load |
| status_clr | input | 6 | Write-one-to-clear strobes for status bits |
| err_status | output | 6 | Sticky status vector |
| mcheck_n | output | 2 | Active-low machine check; bit m drives master m |

## Verification
The assertions assume that the master-identity inputs are meaningful only in a cycle where a matching event pulse is present. They also assume that clear strobes and events may coincide freely. The bench therefore drives every input independently at random, including events, clears and configuration writes that land together in the same cycle. Directed phases first reach each routing rule, the default-master fallback and the clear-versus-event collision one at a time. A behavioural model then predicts the status vector and both machine-check lines on every cycle.

// File: rtl/mcr_pkg.sv
// Package: shared constants and routing classes for the machine-check router.
// Assumes exactly two processor bus masters, so a master index is one bit wide.
package mcr_pkg;

    localparam int unsigned SRC_CNT    = 6;
    localparam int unsigned MASTER_CNT = 2;

    typedef enum logic [1:0] {
        RT_ABUS   = 2'd0,   // current address-bus master
        RT_FIXED0 = 2'd1,   // always master 0
        RT_INIT   = 2'd2    // transaction initiator or default
    } route_e;

    // Map a source index to its routing class.
    function automatic route_e route_of(input int idx);
        if (idx < 2)      return RT_ABUS;
        else if (idx < 4) return RT_FIXED0;
        else              return RT_INIT;
    endfunction

endpackage

// File: rtl/err_latch_cell.sv
// Module: one sticky error status bit plus its captured target master.
// Assumes the candidate target is resolved by the parent for this cycle.
// A clear strobe loses to an event in the same cycle.
module err_latch_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic cand_tgt,
    output logic status,
    output logic tgt
);

    logic status_q;
    logic tgt_q;
    logic capture;

    // Capture a new target only when the bit is clear or being cleared.
    assign capture = evt && (!status_q || clr);

    // Status bit: set by event, cleared by write-one, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (evt)
            status_q <= 1'b1;
        else if (clr)
            status_q <= 1'b0;
    end

    // Target register: loaded on capture, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgt_q <= 1'b0;
        else if (capture)
            tgt_q <= cand_tgt;
    end

    assign status = status_q;
    assign tgt    = tgt_q;

    AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> status_q); // R2
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        status_q && !clr |=> status_q); // R3
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !evt |=> !status_q); // R3
    AST_TARGET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        status_q && !clr |=> $stable(tgt_q)); // R11

endmodule

// File: rtl/mcr_cfg_regs.sv
// Module: enable bits and default-master bit, loaded by one write strobe.
// Assumes the write data is valid in the cycle where cfg_we is high.
module mcr_cfg_regs #(
    parameter int unsigned NUM_SRC = mcr_pkg::SRC_CNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [NUM_SRC-1:0] cfg_enable,
    input  logic               cfg_dflt,
    output logic [NUM_SRC-1:0] en_q,
    output logic               dflt_q
);

    // Configuration storage: cleared on reset, loaded on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            dflt_q <= 1'b0;
        end else if (cfg_we) begin
            en_q   <= cfg_enable;
            dflt_q <= cfg_dflt;
        end
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (en_q == $past(cfg_enable)) && (dflt_q == $past(cfg_dflt))); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(en_q) && $stable(dflt_q)); // R10

endmodule

// File: rtl/mcr_merge.sv
// Module: ORs enabled, set status bits per target master into registered
// active-low machine-check lines. Assumes one-bit target indices.
module mcr_merge #(
    parameter int unsigned NUM_SRC = mcr_pkg::SRC_CNT,
    parameter int unsigned NUM_MST = mcr_pkg::MASTER_CNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] tgt,
    input  logic [NUM_SRC-1:0] en,
    output logic [NUM_MST-1:0] mcheck_n
);

    logic [NUM_SRC-1:0] live;
    logic [NUM_MST-1:0] hit;
    logic [NUM_MST-1:0] mck_q;

    assign live = status & en;

    // Per-master reduction of live sources that target that master.
    for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
        logic [NUM_SRC-1:0] sel;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign sel[s] = live[s] && (tgt[s] == m[0]);
        end
        assign hit[m] = |sel;
    end

    // Output register: active-low, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mck_q <= '1;
        else
            mck_q <= ~hit;
    end

    assign mcheck_n = mck_q;

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (live == '0) |=> (&mcheck_n)); // R4
    AST_ROUTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && en[0]) |=> !mcheck_n[$past(tgt[0])]); // R9

endmodule

// File: rtl/mcheck_router.sv
// Module: top of the bus error machine-check router. Resolves candidate
// targets for each routing class, latches six sticky status bits and drives
// two active-low machine-check lines. Assumes identity inputs are sampled in
// the cycle of the matching event pulse.
module mcheck_router #(
    parameter int unsigned NUM_SRC = mcr_pkg::SRC_CNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_evt,
    input  logic               evt_init_id,
    input  logic               evt_init_valid,
    input  logic               evt_bridge_init,
    input  logic               abus_master,
    input  logic               cfg_we,
    input  logic [NUM_SRC-1:0] cfg_enable,
    input  logic               cfg_dflt,
    input  logic [NUM_SRC-1:0] status_clr,
    output logic [NUM_SRC-1:0] err_status,
    output logic [1:0]         mcheck_n
);
    import mcr_pkg::*;

    localparam int unsigned NUM_MST = MASTER_CNT;

    logic [NUM_SRC-1:0] en_q;
    logic               dflt_q;
    logic [NUM_SRC-1:0] status_vec;
    logic [NUM_SRC-1:0] tgt_vec;
    logic               init_tgt;

    // Initiator target: trusted ID unless bridge-initiated or invalid.
    assign init_tgt = (evt_init_valid && !evt_bridge_init) ? evt_init_id : dflt_q;

    mcr_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_enable (cfg_enable),
        .cfg_dflt   (cfg_dflt),
        .en_q       (en_q),
        .dflt_q     (dflt_q)
    );

    // One latch cell per source; the routing class picks its candidate.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        logic cand;
        if (route_of(i) == RT_ABUS) begin : g_abus
            assign cand = abus_master;
        end else if (route_of(i) == RT_FIXED0) begin : g_fix
            assign cand = 1'b0;
        end else begin : g_init
            assign cand = init_tgt;
        end
        err_latch_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (err_evt[i]),
            .clr      (status_clr[i]),
            .cand_tgt (cand),
            .status   (status_vec[i]),
            .tgt      (tgt_vec[i])
        );
    end

    mcr_merge #(.NUM_SRC(NUM_SRC), .NUM_MST(NUM_MST)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status_vec),
        .tgt      (tgt_vec),
        .en       (en_q),
        .mcheck_n (mcheck_n)
    );

    assign err_status = status_vec;

    AST_PCI_TO_M0: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vec[2] && en_q[2]) |=> !mcheck_n[0]); // R6
    AST_ABUS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt[0] && !status_vec[0]) |=> (tgt_vec[0] == $past(abus_master))); // R5
    AST_INIT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt[4] && !status_vec[4] && evt_init_valid && !evt_bridge_init)
        |=> (tgt_vec[4] == $past(evt_init_id))); // R7
    AST_DFLT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt[5] && !status_vec[5] && evt_bridge_init)
        |=> (tgt_vec[5] == $past(dflt_q))); // R8

endmodule

// File: tb/test_mcheck_router.sv
// Bench: behavioural reference model of the router compared every cycle.
module test_mcheck_router;

    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] err_evt = '0;
    logic         evt_init_id = 1'b0;
    logic         evt_init_valid = 1'b0;
    logic         evt_bridge_init = 1'b0;
    logic         abus_master = 1'b0;
    logic         cfg_we = 1'b0;
    logic [N-1:0] cfg_enable = '0;
    logic         cfg_dflt = 1'b0;
    logic [N-1:0] status_clr = '0;
    logic [N-1:0] err_status;
    logic [1:0]   mcheck_n;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    started = 0;
    string phase = "R1";

    // Reference model state
    bit       m_st [N];
    bit       m_tg [N];
    bit       m_en [N];
    bit       m_dflt;
    bit [1:0] m_mck;

    mcheck_router i_mcheck_router (
        .clk             (clk),
        .rst_n           (rst_n),
        .err_evt         (err_evt),
        .evt_init_id     (evt_init_id),
        .evt_init_valid  (evt_init_valid),
        .evt_bridge_init (evt_bridge_init),
        .abus_master     (abus_master),
        .cfg_we          (cfg_we),
        .cfg_enable      (cfg_enable),
        .cfg_dflt        (cfg_dflt),
        .status_clr      (status_clr),
        .err_status      (err_status),
        .mcheck_n        (mcheck_n)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    task automatic check(input bit ok, input string what, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", phase, what, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Reference model: behavioural, updated at each rising edge.
    always @(posedge clk) begin
        bit [1:0] nm;
        cycles++;
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_st[i] = 0; m_tg[i] = 0; m_en[i] = 0;
            end
            m_dflt = 0;
            m_mck  = 2'b11;
        end else begin
            nm = 2'b11;
            for (int i = 0; i < N; i++)
                if (m_st[i] && m_en[i]) nm[m_tg[i]] = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (err_evt[i] && (!m_st[i] || status_clr[i])) begin
                    m_st[i] = 1;
                    if (i < 2)      m_tg[i] = abus_master;
                    else if (i < 4) m_tg[i] = 0;
                    else            m_tg[i] = (evt_init_valid && !evt_bridge_init) ? evt_init_id : m_dflt;
                end else if (status_clr[i] && !err_evt[i]) begin
                    m_st[i] = 0;
                end
            end
            if (cfg_we) begin
                for (int i = 0; i < N; i++) m_en[i] = cfg_enable[i];
                m_dflt = cfg_dflt;
            end
            m_mck = nm;
        end
    end

    // Compare on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            bit [N-1:0] es;
            for (int i = 0; i < N; i++) es[i] = m_st[i];
            check(err_status == es, "status", int'(err_status), int'(es));
            check(mcheck_n == m_mck, "mcheck_n", int'(mcheck_n), int'(m_mck));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        err_evt = '0; status_clr = '0; cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        phase = "R1";
        @(negedge clk);
        check(err_status == '0, "reset status", int'(err_status), 0);
        check(mcheck_n == 2'b11, "reset mcheck_n", int'(mcheck_n), 3);

        phase = "R10";
        tick(); cfg_we = 1; cfg_enable = 6'h3F; cfg_dflt = 0;
        idle(2);

        phase = "R5";
        tick(); abus_master = 1; err_evt = 6'h01;
        idle(2);
        @(negedge clk);
        check(mcheck_n == 2'b01, "R5 abus to m1", int'(mcheck_n), 1);
        tick(); status_clr = 6'h01; idle(2);

        phase = "R6";
        tick(); abus_master = 1; err_evt = 6'h04;
        idle(2);
        @(negedge clk);
        check(mcheck_n == 2'b10, "R6 pci to m0", int'(mcheck_n), 2);
        tick(); status_clr = 6'h04; idle(2);

        phase = "R7";
        tick(); evt_init_valid = 1; evt_init_id = 1; evt_bridge_init = 0; err_evt = 6'h10;
        idle(2);
        tick(); status_clr = 6'h10; idle(2);

        phase = "R8";
        tick(); cfg_we = 1; cfg_enable = 6'h3F; cfg_dflt = 1;
        tick(); evt_bridge_init = 1; evt_init_id = 0; err_evt = 6'h20;
        idle(2);
        tick(); status_clr = 6'h20; cfg_we = 1; cfg_enable = 6'h3F; cfg_dflt = 0;
        tick(); evt_bridge_init = 0; evt_init_valid = 0; evt_init_id = 1; err_evt = 6'h20;
        idle(2);
        tick(); status_clr = 6'h20; idle(2);

        phase = "R4";
        tick(); cfg_we = 1; cfg_enable = 6'h37; cfg_dflt = 0;
        tick(); err_evt = 6'h08;
        idle(3);
        @(negedge clk);
        check(err_status[3] && mcheck_n == 2'b11, "R4 masked", int'(mcheck_n), 3);
        tick(); cfg_we = 1; cfg_enable = 6'h3F;
        idle(2);

        phase = "R3";
        tick(); status_clr = 6'h08; err_evt = 6'h08;
        idle(2);
        tick(); status_clr = 6'h08;
        idle(2);

        phase = "R11";
        tick(); evt_init_valid = 1; evt_bridge_init = 0; evt_init_id = 0; err_evt = 6'h10;
        tick(); evt_init_id = 1; err_evt = 6'h10;
        idle(2);
        tick(); status_clr = 6'h10; idle(2);

        phase = "R9";
        for (int k = 0; k < 2000; k++) begin
            tick();
            err_evt         = 6'($urandom) & 6'($urandom);
            status_clr      = 6'($urandom) & 6'($urandom);
            abus_master     = 1'($urandom);
            evt_init_id     = 1'($urandom);
            evt_init_valid  = 1'($urandom);
            evt_bridge_init = 1'($urandom);
            cfg_we          = (($urandom % 16) == 0);
            cfg_enable      = 6'($urandom);
            cfg_dflt        = 1'($urandom);
        end
        idle(3);

        phase = "R1";
        tick(); rst_n = 0;
        idle(1);
        rst_n = 1;
        idle(1);
        @(negedge clk);
        check(mcheck_n == 2'b11, "R1 re-reset", int'(mcheck_n), 3);
        finish_run();
    end

endmodule